// File: doc/BRIEF.md
# CBC Decryption Chaining Controller

This block turns a single-block decryption engine into a cipher-block-chaining decryptor that covers a programmed number of 128-bit blocks. All data crosses its register-style ports as 16-bit half-words. Three request strobes pace an external DMA engine. The chaining strobe asks for a 128-bit chaining value on a dedicated port: the initialization vector for the first block, then the previous ciphertext block. The input strobe asks for the next ciphertext block. The output strobe announces that a plaintext block is ready to be read.

The chaining value is never kept inside the block. It is always pushed in from outside. Once the eighth ciphertext half-word has been written, the block starts the external decryption core. That core sits behind a one-cycle start pulse and a one-cycle done pulse, with 128-bit data in each direction. The raw core result is held until the chaining register is complete and the previous plaintext has been fully read. It is then XORed with the chaining value and offered for readout.

Writing a non-zero block count under a valid configuration starts a run. A busy flag covers the whole run. A sticky done flag marks its end and is cleared by a strobe.

Top module: `cbc_dec_ctrl`

## Requirements
- R1: A 128-bit register is filled by exactly 8 half-word writes, write k (k = 0..7) landing in bits [16k+15:16k]. A write made while the register already holds 8 half-words and has not been consumed has no effect.
- R2: A run starts when the block count is written with a non-zero value while idle and the configuration is valid: chaining enable = 1, chaining mode = 2'b01, and operation = 2'b01 or 2'b11. In the cycle after that write, busy is high and the chaining and input requests each pulse.
- R3: A block-count write is ignored, with busy staying low and no request or core start raised, when the count is zero or the configuration is invalid. A block-count write made while busy does not change the number of blocks in the running job.
- R4: `core_start` is high in the cycle after the clock edge that stores the 8th ciphertext half-word, and `core_ct` then carries the assembled block.
- R5: Plaintext block 0 equals the core result XOR the initialization vector. Plaintext block i > 0 equals the core result XOR ciphertext block i-1, as supplied on the chaining port.
- R6: A core result is not combined until all 8 chaining half-words are present. If the core finishes first, no output request is raised until the chaining register is complete.
- R7: A plaintext block is read as 8 half-words, lowest first. `pt_hw` shows the current half-word, and each `pt_rd` advances to the next one.
- R8: The output request pulses in the cycle after a block is combined. For every block except the last, the chaining and input requests pulse in that same cycle. For the last block they stay low.
- R9: Busy falls and done rises in the cycle after the read of the final half-word of the final block. Done then stays high until `done_clr` is pulsed.
- R10: Every request output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chain_en | input | 1 | Chaining enable |
| cfg_chain_mode | input | 2 | Chaining mode select, 2'b01 = CBC |
| cfg_op | input | 2 | Operation, 2'b01 decrypt, 2'b11 decrypt with pre-expanded key |
| blk_cnt_wr | input | 1 | Block-count write strobe |
| blk_cnt | input | CNT_W | Number of blocks |
| chain_wr | input | 1 | Chaining half-word write strobe |
| chain_hw | input | 16 | Chaining half-word |
| ct_wr | input | 1 | Ciphertext half-word write strobe |
| ct_hw | input | 16 | Ciphertext half-word |
| pt_rd | input | 1 | Plaintext half-word read strobe |
| pt_hw | output | 16 | Current plaintext half-word |
| req_chain | output | 1 | Request for a chaining value |
| req_out | output | 1 | Plaintext block ready |
| req_in | output | 1 | Request for the next ciphertext block |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky end-of-run flag |
| done_clr | input | 1 | Clears done |
| core_start | output | 1 | Start pulse to the decryption core |
| core_ct | output | 128 | Block handed to the core |
| core_done | input | 1 | Core result valid pulse |
| core_res | input | 128 | Raw core result |

## Verification
On every cycle, the assertions check that:
- each request is a one-cycle pulse;
- nothing is requested or started while idle;
- a plaintext block is never offered without a complete chaining value;
- a register never counts past 8 half-words;
- busy and done are never high together.

Only the bench scenarios can show the things that need end-to-end values. These are the XOR against the initialization vector and the earlier ciphertext, the half-word ordering, and the placement of the final strobe. The scenarios also cover the stalls: a core that finishes before the chaining value is complete, and redundant writes that must leave a block unchanged.

// File: rtl/cbc_dec_pkg.sv
// Shared widths and configuration decoding for the CBC decryption controller.
// Assumes the block width is a whole multiple of the half-word width.
package cbc_dec_pkg;
    localparam int HW_W       = 16;
    localparam int BLK_W      = 128;
    localparam int HW_PER_BLK = BLK_W / HW_W;

    localparam logic [1:0] MODE_CBC    = 2'b01;
    localparam logic [1:0] OP_DEC      = 2'b01;
    localparam logic [1:0] OP_DEC_PREK = 2'b11;

    // True when the configuration selects CBC chaining with a decrypt operation.
    function automatic logic cfg_valid(input logic en, input logic [1:0] mode,
                                       input logic [1:0] op);
        return en && (mode == MODE_CBC) && ((op == OP_DEC) || (op == OP_DEC_PREK));
    endfunction
endpackage

// File: rtl/cbc_hw_packer.sv
// Collects N half-word writes into one block register, lowest lane first.
// Assumes clr has priority over wr; writes past the Nth are dropped until clr.
module cbc_hw_packer #(
    parameter int HW_W  = 16,
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [HW_W-1:0]  wdata,
    output logic             full,
    output logic [BLK_W-1:0] blk
);
    localparam int N  = BLK_W / HW_W;
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] fill_q;

    // Track how many lanes have been written since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fill_q <= '0;
        else if (clr)                        fill_q <= '0;
        else if (wr && (fill_q != CW'(N)))   fill_q <= fill_q + CW'(1);
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            // Store the write into lane g when it is the next lane to fill.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    blk[g*HW_W +: HW_W] <= '0;
                else if (!clr && wr && (fill_q == CW'(g)))
                    blk[g*HW_W +: HW_W] <= wdata;
            end
        end
    endgenerate

    assign full = (fill_q == CW'(N));

    a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CW'(N));
    a_r1_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);
endmodule

// File: rtl/cbc_hw_unpacker.sv
// Holds one plaintext block and presents it one half-word at a time, lowest lane first.
// Assumes load only arrives when the previous block has been fully read.
module cbc_hw_unpacker #(
    parameter int HW_W  = 16,
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BLK_W-1:0] blk,
    input  logic             rd,
    output logic             valid,
    output logic [HW_W-1:0]  hw,
    output logic             last_rd
);
    localparam int N  = BLK_W / HW_W;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [BLK_W-1:0] hold_q;
    logic [IW-1:0]    idx_q;
    logic [HW_W-1:0]  lanes [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            assign lanes[g] = hold_q[g*HW_W +: HW_W];
        end
    endgenerate

    assign hw      = lanes[idx_q];
    assign last_rd = rd && valid && (idx_q == IW'(N - 1));

    // Capture a new block, or step the read pointer and drop valid after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            idx_q  <= '0;
            valid  <= 1'b0;
        end else if (load) begin
            hold_q <= blk;
            idx_q  <= '0;
            valid  <= 1'b1;
        end else if (rd && valid) begin
            if (last_rd) begin
                idx_q <= '0;
                valid <= 1'b0;
            end else begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    a_r7_load_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
endmodule

// File: rtl/cbc_dec_seq.sv
// Run sequencer: starts a job, launches the core, decides when a result may be
// combined, paces the three requests and signals the end of the job.
// Assumes the core accepts one block at a time and answers with one done pulse.
module cbc_dec_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cfg_ok,
    input  logic             din_full,
    input  logic             xin_full,
    input  logic             core_done,
    input  logic             out_valid,
    input  logic             last_rd,
    input  logic             done_clr,
    output logic             start,
    output logic             go,
    output logic             combine,
    output logic             trig_chain,
    output logic             trig_in,
    output logic             trig_out,
    output logic             busy,
    output logic             done
);
    typedef enum logic {S_IDLE, S_RUN} state_t;

    state_t           state_q;
    logic [CNT_W-1:0] left_q;
    logic             core_busy_q;
    logic             res_valid_q;
    logic             finish;
    logic             more;

    assign busy    = (state_q == S_RUN);
    assign start   = (state_q == S_IDLE) && cnt_wr && (cnt_val != '0) && cfg_ok;
    assign go      = busy && din_full && !core_busy_q && !res_valid_q;
    assign combine = busy && res_valid_q && xin_full && !out_valid;
    assign more    = left_q > CNT_W'(1);
    assign finish  = busy && last_rd && (left_q == '0);

    // Main state: idle until a valid start, running until the final readout.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= S_IDLE;
        else if (start)  state_q <= S_RUN;
        else if (finish) state_q <= S_IDLE;
    end

    // Blocks still to be combined in this run.
    always_ff @(posedge clk) begin
        if (!rst_n)       left_q <= '0;
        else if (start)   left_q <= cnt_val;
        else if (combine) left_q <= left_q - CNT_W'(1);
    end

    // Core occupancy and held-result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_busy_q <= 1'b0;
            res_valid_q <= 1'b0;
        end else begin
            if (go)             core_busy_q <= 1'b1;
            else if (core_done) core_busy_q <= 1'b0;
            if (core_done && core_busy_q) res_valid_q <= 1'b1;
            else if (combine)             res_valid_q <= 1'b0;
        end
    end

    // Registered request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_chain <= 1'b0;
            trig_in    <= 1'b0;
            trig_out   <= 1'b0;
        end else begin
            trig_chain <= start || (combine && more);
            trig_in    <= start || (combine && more);
            trig_out   <= combine;
        end
    end

    // Sticky completion flag, cleared by a new run or by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (start)    done <= 1'b0;
        else if (finish)   done <= 1'b1;
        else if (done_clr) done <= 1'b0;
    end

    a_r10_chain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_chain |=> !trig_chain);
    a_r10_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in |=> !trig_in);
    a_r10_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr && !start) |=> done);
endmodule

// File: rtl/cbc_dec_ctrl.sv
// CBC decryption chaining controller top. It packs ciphertext and chaining
// half-words, drives the external core, XORs the held core result with the
// pushed-in chaining value and unpacks the plaintext.
// Assumes the DMA honours each request with exactly 8 half-word transfers.
module cbc_dec_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_chain_en,
    input  logic [1:0]       cfg_chain_mode,
    input  logic [1:0]       cfg_op,
    input  logic             blk_cnt_wr,
    input  logic [CNT_W-1:0] blk_cnt,
    input  logic             chain_wr,
    input  logic [15:0]      chain_hw,
    input  logic             ct_wr,
    input  logic [15:0]      ct_hw,
    input  logic             pt_rd,
    output logic [15:0]      pt_hw,
    output logic             req_chain,
    output logic             req_out,
    output logic             req_in,
    output logic             busy,
    output logic             done,
    input  logic             done_clr,
    output logic             core_start,
    output logic [127:0]     core_ct,
    input  logic             core_done,
    input  logic [127:0]     core_res
);
    import cbc_dec_pkg::*;

    logic             start, go, combine;
    logic             din_full, xin_full, out_valid, last_rd;
    logic [BLK_W-1:0] xin_blk;
    logic [BLK_W-1:0] res_q;

    cbc_hw_packer #(.HW_W(HW_W), .BLK_W(BLK_W)) u_ct_pack (
        .clk(clk), .rst_n(rst_n), .clr(start || go), .wr(ct_wr), .wdata(ct_hw),
        .full(din_full), .blk(core_ct));

    cbc_hw_packer #(.HW_W(HW_W), .BLK_W(BLK_W)) u_chain_pack (
        .clk(clk), .rst_n(rst_n), .clr(start || combine), .wr(chain_wr),
        .wdata(chain_hw), .full(xin_full), .blk(xin_blk));

    // Hold the raw core result until it can be combined.
    always_ff @(posedge clk) begin
        if (!rst_n)         res_q <= '0;
        else if (core_done) res_q <= core_res;
    end

    cbc_hw_unpacker #(.HW_W(HW_W), .BLK_W(BLK_W)) u_pt_unpack (
        .clk(clk), .rst_n(rst_n), .load(combine), .blk(res_q ^ xin_blk),
        .rd(pt_rd), .valid(out_valid), .hw(pt_hw), .last_rd(last_rd));

    cbc_dec_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cnt_wr(blk_cnt_wr), .cnt_val(blk_cnt),
        .cfg_ok(cfg_valid(cfg_chain_en, cfg_chain_mode, cfg_op)),
        .din_full(din_full), .xin_full(xin_full), .core_done(core_done),
        .out_valid(out_valid), .last_rd(last_rd), .done_clr(done_clr),
        .start(start), .go(go), .combine(combine),
        .trig_chain(req_chain), .trig_in(req_in), .trig_out(req_out),
        .busy(busy), .done(done));

    assign core_start = go;

    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(req_chain || req_in || req_out || core_start));
    a_r6_out_needs_chain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> $past(xin_full));
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);
endmodule

// File: tb/tb_cbc_dec_ctrl.sv
`timescale 1ns/1ps
module tb_cbc_dec_ctrl;
    localparam int NJOB = 4;
    // Stimulus table: blocks, core latency, late chaining, operation encoding.
    localparam int         T_NBLK [NJOB] = '{1, 3, 2, 4};
    localparam int         T_LAT  [NJOB] = '{3, 2, 6, 1};
    localparam bit         T_LATE [NJOB] = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [1:0] T_OP   [NJOB] = '{2'b01, 2'b11, 2'b01, 2'b11};
    localparam logic [127:0] KMASK = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_chain_en = 1'b1;
    logic [1:0] cfg_chain_mode = 2'b01, cfg_op = 2'b01;
    logic blk_cnt_wr = 1'b0;
    logic [15:0] blk_cnt = '0;
    logic chain_wr = 1'b0, ct_wr = 1'b0, pt_rd = 1'b0, done_clr = 1'b0;
    logic [15:0] chain_hw = '0, ct_hw = '0;
    logic [15:0] pt_hw;
    logic req_chain, req_out, req_in, busy, done, core_start;
    logic [127:0] core_ct;
    logic core_done;
    logic [127:0] core_res;

    int n_chk = 0;
    int n_bad = 0;
    int core_lat = 1;
    int core_cnt = 0;
    logic [127:0] core_buf = '0;

    always #2.5 clk = ~clk;

    cbc_dec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_chain_en(cfg_chain_en),
        .cfg_chain_mode(cfg_chain_mode), .cfg_op(cfg_op),
        .blk_cnt_wr(blk_cnt_wr), .blk_cnt(blk_cnt), .chain_wr(chain_wr),
        .chain_hw(chain_hw), .ct_wr(ct_wr), .ct_hw(ct_hw), .pt_rd(pt_rd),
        .pt_hw(pt_hw), .req_chain(req_chain), .req_out(req_out), .req_in(req_in),
        .busy(busy), .done(done), .done_clr(done_clr), .core_start(core_start),
        .core_ct(core_ct), .core_done(core_done), .core_res(core_res));

    // Stand-in cipher: swap the halves and XOR a mask.
    function automatic logic [127:0] stand_in(input logic [127:0] c);
        return {c[63:0], c[127:64]} ^ KMASK;
    endfunction

    function automatic logic [127:0] make_ct(input int job, input int i);
        logic [31:0] s;
        s = 32'h9e3779b9 * (i + 1) + 32'(job * 7919);
        return {s, ~s, s ^ 32'h5a5a5a5a, s + 32'h13579bdf};
    endfunction

    function automatic logic [127:0] make_iv(input int job);
        return {4{32'hc0de0000 + 32'(job)}};
    endfunction

    // Stand-in core with a programmable latency.
    always @(posedge clk) begin
        if (core_start) begin
            core_buf <= stand_in(core_ct);
            core_cnt <= core_lat;
        end else if (core_cnt != 0) begin
            core_cnt <= core_cnt - 1;
        end
    end
    assign core_done = (core_cnt == 1);
    assign core_res  = core_buf;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R10: every request observed must be low in the following cycle.
    logic p_chain = 1'b0, p_in = 1'b0, p_out = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_chain) chk(!req_chain, "R10 chain pulse", 128'(req_chain), 128'd0);
            if (p_in)    chk(!req_in, "R10 in pulse", 128'(req_in), 128'd0);
            if (p_out)   chk(!req_out, "R10 out pulse", 128'(req_out), 128'd0);
        end
        p_chain = req_chain;
        p_in    = req_in;
        p_out   = req_out;
    end

    task automatic wr_chain(input logic [15:0] d);
        chain_wr = 1'b1; chain_hw = d;
        @(negedge clk);
        chain_wr = 1'b0;
    endtask

    task automatic wr_ct(input logic [15:0] d);
        ct_wr = 1'b1; ct_hw = d;
        @(negedge clk);
        ct_wr = 1'b0;
    endtask

    task automatic write_cnt(input logic [15:0] n);
        blk_cnt_wr = 1'b1; blk_cnt = n;
        @(negedge clk);
        blk_cnt_wr = 1'b0;
    endtask

    task automatic send_ct(input int job, input int i);
        logic [127:0] c;
        c = make_ct(job, i);
        for (int k = 0; k < 8; k++) wr_ct(c[16*k +: 16]);
        chk(core_start === 1'b1, "R4 core_start after 8th write", 128'(core_start), 128'd1);
        chk(core_ct === c, "R1/R4 assembled ciphertext", core_ct, c);
    endtask

    task automatic send_chain(input logic [127:0] v, input bit extra);
        for (int k = 0; k < 8; k++) wr_chain(v[16*k +: 16]);
        if (extra) wr_chain(16'hdead);
    endtask

    task automatic run_job(input int job);
        int nb;
        logic [127:0] chv, pt;
        bit seen;
        nb = T_NBLK[job];
        core_lat = T_LAT[job];
        cfg_op = T_OP[job];
        write_cnt(16'(nb));
        chk(busy && req_chain && req_in, "R2 start strobes",
            {125'd0, busy, req_chain, req_in}, 128'd7);
        for (int i = 0; i < nb; i++) begin
            chv = (i == 0) ? make_iv(job) : make_ct(job, i - 1);
            pt  = stand_in(make_ct(job, i)) ^ chv;
            if (job == 1 && i == 1) write_cnt(16'd7);
            if (!T_LATE[job]) begin
                send_chain(chv, 1'b1);
                send_ct(job, i);
            end else begin
                send_ct(job, i);
                repeat (core_lat + 3) @(negedge clk);
                chk(req_out === 1'b0, "R6 waits for chaining value", 128'(req_out), 128'd0);
                send_chain(chv, 1'b0);
            end
            seen = 1'b0;
            for (int w = 0; w < 100 && !seen; w++) begin
                if (req_out) seen = 1'b1;
                else @(negedge clk);
            end
            chk(seen, "R8 output request raised", 128'(seen), 128'd1);
            chk(req_chain === (i < nb - 1) && req_in === (i < nb - 1),
                "R8 follow-on requests", {126'd0, req_chain, req_in},
                (i < nb - 1) ? 128'd3 : 128'd0);
            for (int k = 0; k < 8; k++) begin
                chk(pt_hw === pt[16*k +: 16], "R5/R7 plaintext half-word",
                    128'(pt_hw), 128'(pt[16*k +: 16]));
                pt_rd = 1'b1;
                @(negedge clk);
                pt_rd = 1'b0;
            end
            if (i == nb - 1)
                chk(!busy && done, "R9 end of run", {126'd0, busy, done}, 128'd1);
            else
                chk(busy && !done, "R9 still running", {126'd0, busy, done}, 128'd2);
        end
        repeat (3) @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R3/R9 done held, count rewrite ignored",
            {126'd0, busy, done}, 128'd1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk(done === 1'b0, "R9 done cleared", 128'(done), 128'd0);
    endtask

    task automatic expect_no_start(input string tag);
        bit any;
        any = 1'b0;
        for (int c = 0; c < 6; c++) begin
            if (busy || req_chain || req_in || req_out || core_start) any = 1'b1;
            @(negedge clk);
        end
        chk(!any, tag, 128'(any), 128'd0);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !req_chain && !req_in && !req_out && !core_start,
            "reset state", {122'd0, busy, done, req_chain, req_in, req_out, core_start},
            128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R2 idle after reset", {126'd0, busy, done}, 128'd0);

        for (int j = 0; j < NJOB; j++) run_job(j);

        write_cnt(16'd0);
        expect_no_start("R3 zero count ignored");
        cfg_chain_mode = 2'b10;
        write_cnt(16'd2);
        expect_no_start("R3 non-CBC mode ignored");
        cfg_chain_mode = 2'b01;
        cfg_op = 2'b10;
        write_cnt(16'd2);
        expect_no_start("R3 non-decrypt operation ignored");
        cfg_op = 2'b01;
        cfg_chain_en = 1'b0;
        write_cnt(16'd2);
        expect_no_start("R3 chaining disabled ignored");
        cfg_chain_en = 1'b1;

        run_job(0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule